// File: doc/BRIEF.md
# Signaling Change FIFO with Interrupt Status

This block queues the timeslot addresses of channels whose command/indication or signaling value has changed, and raises an interrupt while any such address waits to be collected. A change detector elsewhere strobes `chg_push` with a 6-bit timeslot address. The processor collects addresses one at a time through a show-ahead read port. It can also discard the whole queue with a single clear command.

The pending-change status is not a latched event. It is bit 7 of an 8-bit status byte, and it follows the queue's occupancy directly. Reading the byte leaves it unchanged. The bit goes low only when the queue has been drained or cleared. A mask bit gates the interrupt pin and leaves the status bit untouched. A push that arrives while the queue is full is dropped, and a sticky overflow flag records the loss.

Top module: `sigchg_irq`

## Requirements
- R1: `stat_reg[7]` is 1 in every cycle in which the queue holds at least one entry, and 0 when it is empty. `stat_reg[6:0]` always read 0.
- R2: `stat_reg` is a pure view of state. Observing it over any number of cycles changes nothing, and with no pop and no clear a set bit 7 stays set.
- R3: Entries leave in arrival order. `rd_data` shows the oldest 6-bit address while the queue is non-empty. `rd_pop` removes that entry at the clock edge. Bit 7 falls in the cycle after the last entry is popped.
- R4: `fifo_clr`=1 empties the queue and clears `ovf` at the next edge. It overrides any push or pop in the same cycle.
- R5: `irq` = `stat_reg[7]` AND NOT `mask_q`. `mask_we`=1 loads `mask_wdata` into `mask_q` at the edge. The mask never alters `stat_reg`.
- R6: The queue holds 16 entries. Sixteen pushes into an empty queue are all stored and all read back.
- R7: A push into a full queue with no pop in the same cycle is dropped. `ovf` becomes 1 at the next edge and stays 1 until `fifo_clr`.
- R8: `rd_pop` on an empty queue has no effect, and `rd_data` reads 0 whenever the queue is empty.
- R9: A push and a pop in the same cycle leave the occupancy unchanged. On a full queue the push is stored and `ovf` is not set.
- R10: After reset the queue is empty, `stat_reg`=0x00, `mask_q`=0, `irq`=0 and `ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_push | input | 1 | Change detected, store `chg_addr` |
| chg_addr | input | 6 | Timeslot address of the change |
| rd_pop | input | 1 | Processor consumes the head entry |
| rd_data | output | 6 | Head entry, 0 when empty |
| fifo_clr | input | 1 | Clear command for the queue |
| mask_we | input | 1 | Load the mask bit |
| mask_wdata | input | 1 | New mask value |
| stat_reg | output | 8 | Status byte, bit 7 = changes pending |
| mask_q | output | 1 | Current mask bit |
| irq | output | 1 | Interrupt pin, active high |
| ovf | output | 1 | Sticky overflow flag |

## Verification
The first pattern is a short burst followed by idle cycles and a drain. It separates a level-derived status bit from a read-to-clear latch and confirms arrival order. The second pattern overfills the queue by two and then pushes and pops together while full. It distinguishes dropping at the tail from overwriting, and shows whether a simultaneous push and pop is treated as an overflow. The last patterns pop an empty queue, toggle the mask while entries are pending, and issue a clear alongside a push. Together they show that the mask reaches only the pin and that the clear takes priority.

// File: rtl/sigchg_pkg.sv
package sigchg_pkg;
  localparam int STAT_W  = 8;
  localparam int PEND_BIT = 7;

  // Build the status byte from the pending flag; other bits belong elsewhere.
  function automatic logic [STAT_W-1:0] stat_pack(input logic pend);
    logic [STAT_W-1:0] s;
    s = '0;
    s[PEND_BIT] = pend;
    return s;
  endfunction
endpackage

// File: rtl/sigchg_fifo.sv
module sigchg_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 6,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          ovf_evt
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level;
  logic          full;
  logic          acc_push, acc_pop;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  function automatic logic [CW-1:0] level_next(input logic [CW-1:0] l,
                                               input logic w, input logic r);
    return l + CW'(w) - CW'(r);
  endfunction

  assign empty    = (level == '0);
  assign full     = (level == CW'(DEPTH));
  assign acc_pop  = pop & ~empty & ~clr;
  assign acc_push = push & ~clr & (~full | acc_pop);
  assign ovf_evt  = push & ~clr & full & ~acc_pop;
  assign head_data = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (acc_push) wr_ptr <= ptr_next(wr_ptr);
      if (acc_pop)  rd_ptr <= ptr_next(rd_ptr);
      level <= level_next(level, acc_push, acc_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (acc_push) mem[wr_ptr] <= push_data;
  end

  // R4: clear empties the queue
  p_clear_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
  // R7: a dropped push leaves the queue full
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (level == CW'(DEPTH)));
  // R9: simultaneous accepted push and pop keep the occupancy
  p_pushpop_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_push && acc_pop) |=> $stable(level));
  // R8: popping an empty queue moves nothing
  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push && !clr) |=> ($stable(rd_ptr) && empty));
endmodule

// File: rtl/sigchg_intr.sv
module sigchg_intr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ovf_evt,
  input  logic empty,
  input  logic mask_we,
  input  logic mask_wdata,
  output logic pend,
  output logic mask_q,
  output logic ovf_q,
  output logic irq
);
  assign pend = ~empty;
  assign irq  = pend & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= mask_wdata;
      if (clr)          ovf_q <= 1'b0;
      else if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  // R7: overflow flag is sticky until a clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q);
  // R5: a set mask silences the pin
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);
  // R4: clear drops the overflow flag
  p_clr_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovf_q);
endmodule

// File: rtl/sigchg_irq.sv
module sigchg_irq #(
  parameter int DEPTH = 16,
  parameter int AW_TS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chg_push,
  input  logic [AW_TS-1:0] chg_addr,
  input  logic             rd_pop,
  output logic [AW_TS-1:0] rd_data,
  input  logic             fifo_clr,
  input  logic             mask_we,
  input  logic             mask_wdata,
  output logic [7:0]       stat_reg,
  output logic             mask_q,
  output logic             irq,
  output logic             ovf
);
  import sigchg_pkg::*;

  logic empty_w, ovf_evt_w, pend_w;

  sigchg_fifo #(.DEPTH(DEPTH), .DW(AW_TS)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .push      (chg_push),
    .push_data (chg_addr),
    .pop       (rd_pop),
    .head_data (rd_data),
    .empty     (empty_w),
    .ovf_evt   (ovf_evt_w)
  );

  sigchg_intr u_intr (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .ovf_evt    (ovf_evt_w),
    .empty      (empty_w),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .pend       (pend_w),
    .mask_q     (mask_q),
    .ovf_q      (ovf),
    .irq        (irq)
  );

  assign stat_reg = stat_pack(pend_w);

  // R1: pending status and head data agree with queue occupancy
  p_pend_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_reg[7] |-> (rd_data == '0));
  // R2: with no pop and no clear, a set status bit stays set
  p_status_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_reg[7] && !rd_pop && !fifo_clr) |=> stat_reg[7]);
endmodule

// File: tb/sigchg_irq_bench.sv
module sigchg_irq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chg_push = 1'b0;
  logic [5:0] chg_addr = '0;
  logic       rd_pop = 1'b0;
  logic [5:0] rd_data;
  logic       fifo_clr = 1'b0;
  logic       mask_we = 1'b0;
  logic       mask_wdata = 1'b0;
  logic [7:0] stat_reg;
  logic       mask_q, irq, ovf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  string phase = "R10";

  logic [5:0] exp_q[$];
  bit exp_ovf = 0;
  bit exp_mask = 0;

  always #4 clk = ~clk;

  sigchg_irq u_sigchg_irq (
    .clk(clk), .rst_n(rst_n), .chg_push(chg_push), .chg_addr(chg_addr),
    .rd_pop(rd_pop), .rd_data(rd_data), .fifo_clr(fifo_clr),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .stat_reg(stat_reg),
    .mask_q(mask_q), .irq(irq), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (phase %s) actual=%0h expected=%0h at %0t", req, phase, act, exp, $time);
    end
  endtask

  // Driver: apply one cycle of stimulus just after the rising edge
  task automatic drive(input bit p, input logic [5:0] a, input bit r,
                       input bit c, input bit mw, input bit md);
    @(posedge clk); #2;
    chg_push = p; chg_addr = a; rd_pop = r;
    fifo_clr = c; mask_we = mw; mask_wdata = md;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 6'h0, 0, 0, 0, 0);
  endtask

  // Monitor / scoreboard: compare outputs, then advance the model for the coming edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [5:0] head;
      bit pend;
      head = (exp_q.size() != 0) ? exp_q[0] : 6'h0;
      pend = (exp_q.size() != 0);
      chk(rd_data == head, (pend ? "R3" : "R8"), rd_data, head);
      chk(stat_reg == {pend, 7'b0}, "R1", stat_reg, {pend, 7'b0});
      chk(irq == (pend & ~exp_mask), "R5", irq, pend & ~exp_mask);
      chk(mask_q == exp_mask, "R5", mask_q, exp_mask);
      chk(ovf == exp_ovf, "R7", ovf, exp_ovf);
      if (mask_we) exp_mask = mask_wdata;
      if (fifo_clr) begin
        exp_q.delete();
        exp_ovf = 0;
      end else begin
        bit popped;
        popped = 0;
        if (rd_pop && exp_q.size() != 0) begin
          void'(exp_q.pop_front());
          popped = 1;
        end
        if (chg_push) begin
          if (exp_q.size() < 16) exp_q.push_back(chg_addr);
          else exp_ovf = 1;
        end
        if (popped && chg_push && exp_q.size() > 16) exp_ovf = 1;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(stat_reg == 8'h00, "R10", stat_reg, 0);
    chk(irq == 1'b0, "R10", irq, 0);
    chk(ovf == 1'b0, "R10", ovf, 0);
    chk(mask_q == 1'b0, "R10", mask_q, 0);
    chk(rd_data == 6'h0, "R10", rd_data, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    // R2/R3: short burst, idle (status holds), drain in order
    phase = "R2";
    drive(1, 6'h11, 0, 0, 0, 0);
    drive(1, 6'h2A, 0, 0, 0, 0);
    drive(1, 6'h3F, 0, 0, 0, 0);
    idle(5);
    phase = "R3";
    for (int i = 0; i < 3; i++) drive(0, 6'h0, 1, 0, 0, 0);
    idle(2);

    // R8: popping an empty queue
    phase = "R8";
    drive(0, 6'h0, 1, 0, 0, 0);
    drive(0, 6'h0, 1, 0, 0, 0);
    idle(2);

    // R6: fill all sixteen slots
    phase = "R6";
    for (int i = 0; i < 16; i++) drive(1, 6'(i * 3 + 1), 0, 0, 0, 0);
    idle(2);
    // R7: two pushes beyond capacity are dropped
    phase = "R7";
    drive(1, 6'h3E, 0, 0, 0, 0);
    drive(1, 6'h3D, 0, 0, 0, 0);
    idle(2);
    // R9: push and pop together while full
    phase = "R9";
    drive(1, 6'h05, 1, 0, 0, 0);
    drive(1, 6'h06, 1, 0, 0, 0);
    idle(1);
    phase = "R6";
    for (int i = 0; i < 16; i++) drive(0, 6'h0, 1, 0, 0, 0);
    idle(2);

    // R5: mask gates only the pin
    phase = "R5";
    drive(1, 6'h21, 0, 0, 0, 0);
    drive(1, 6'h22, 0, 0, 1, 1);
    idle(3);
    drive(0, 6'h0, 0, 0, 1, 0);
    idle(2);

    // R4: clear wins over a simultaneous push and pop, and drops ovf
    phase = "R4";
    drive(1, 6'h33, 1, 1, 0, 0);
    idle(3);

    // R9: push and pop on an empty queue stores the push
    phase = "R9";
    drive(1, 6'h2B, 1, 0, 0, 0);
    idle(2);
    drive(1, 6'h2C, 1, 0, 0, 0);
    drive(0, 6'h0, 1, 0, 0, 0);
    idle(3);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule